// File: doc/BRIEF.md
# Base-Cell Pattern Memory Tester

This block is a built-in self-test controller for a one-bit-wide synchronous RAM of `N` words. After a start pulse it drives address, write data, write enable and read enable into the memory under test, then checks every returned bit against the value the pattern predicts. The test moves a single base cell through the array. For each base position the whole array is first filled with a background value, and the base cell then receives the complement. Every other cell is then read against that base cell.

Two read orderings are available, and `mode` selects between them at start. In galloping order the base cell is read again straight after each read of another cell. In walking order all other cells are read first and the base cell is read once at the end. A full pass uses a background of 0. A second full pass follows with a background of 1. The test time therefore grows with N².

The memory answers a read one cycle after the read is issued. The tester compares that data against an expected bit that it carries along in a pipeline stage. The first mismatch sets a sticky fail flag and captures the failing address and the bit that was expected. The test still runs to its end, and `done` then pulses.

Top module: `bcell_tester`

## Requirements
- R1: A `start` pulse while idle begins the test. `busy` is high from the next cycle and stays high until the cycle in which `done` is high for exactly one cycle; `busy` is low in that cycle. A `start` pulse while busy has no effect on the operation stream.
- R2: For each base position the tester writes the background value to addresses 0 to N-1 in ascending order, one per cycle. In the next cycle it writes the complement of the background to the base address.
- R3: With `mode`=0 (galloping), every address other than the base is read in ascending order, expecting the background value. Each such read is followed in the next cycle by a read of the base address, expecting the complement.
- R4: With `mode`=1 (walking), every address other than the base is read in ascending order, expecting the background value. The base address is then read once, last, expecting the complement.
- R5: The base address takes the values 0, 1, …, N-1 in turn within a pass.
- R6: The first pass uses background 0. The second pass uses background 1. The test ends after the second pass.
- R7: Read data is compared in the cycle after the read is issued. A mismatch sets `fail` in the following cycle, and `fail` stays set until the next accepted start.
- R8: On the first mismatch, `fail_addr` and `fail_exp` capture the read address and the expected bit. Later mismatches leave them unchanged, and the operation stream runs to its full length.
- R9: `mode` is sampled only when `start` is accepted. Changing it while busy does not alter the ordering.
- R10: After reset the tester is idle. `busy`, `done` and `fail` are low, and `mem_we` and `mem_en` are low.
- R11: An accepted start clears `fail`, `fail_addr` and `fail_exp`.
- R12: After the final read there is exactly one drain cycle with no memory operation and `busy` high. `done` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test when idle |
| mode | input | 1 | 0 = galloping order, 1 = walking order |
| mem_addr | output | $clog2(N) | Address to the memory under test |
| mem_en | output | 1 | Read enable; data is returned one cycle later |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 1 | Write data bit |
| mem_rdata | input | 1 | Read data bit from the memory under test |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse at completion |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | $clog2(N) | Address of the first mismatch |
| fail_exp | output | 1 | Expected bit of the first mismatch |

## Verification
The bench builds the tester with N=8. This size keeps each complete run to a few hundred cycles. It still puts the base cell at both ends of the array, and in the middle where the skipped address splits the other-cell sweep. A behavioural memory in the bench can inject a stuck-at cell or a one-way bridge from an aggressor to a victim. These faults exercise the first-failure capture with several later mismatches, and they give a failing address that differs from the base address. Both orderings run back to back, so the bench also sees that the fail flag clears on the next start.

// File: rtl/bcell_pkg.sv
package bcell_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SETB,
        ST_SWEEP,
        ST_LAST,
        ST_DRAIN,
        ST_DONE
    } bc_state_e;

    typedef enum logic {
        ORD_GALLOP = 1'b0,
        ORD_WALK   = 1'b1
    } bc_order_e;

    // expected-value tag carried alongside a read into the compare stage
    typedef struct packed {
        logic valid;
        logic exp;
    } bc_rdtag_t;

    function automatic bit bc_size_ok(int n);
        return (n >= 4) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/bcell_seq.sv
module bcell_seq
    import bcell_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode,
    output logic [AW-1:0] mem_addr,
    output logic          mem_en,
    output logic          mem_we,
    output logic          mem_wdata,
    output bc_rdtag_t     rd_tag,
    output logic          busy,
    output logic          done,
    output logic          clear
);

    localparam logic [AW-1:0] TOP_ADDR  = AW'(N - 1);
    localparam logic [AW-1:0] TOP_OTHER = AW'(N - 2);

    bc_state_e     state_q;
    bc_order_e     order_q;
    logic          bg_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] idx_q;
    logic          half_q;
    logic [AW-1:0] other;

    // k-th address that is not the base
    assign other = (idx_q < base_q) ? idx_q : idx_q + AW'(1);

    assign clear = (state_q == ST_IDLE) && start;
    assign busy  = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done  = (state_q == ST_DONE);

    always_comb begin
        mem_addr   = '0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_wdata  = 1'b0;
        rd_tag     = '0;
        unique case (state_q)
            ST_FILL: begin
                mem_we    = 1'b1;
                mem_addr  = idx_q;
                mem_wdata = bg_q;
            end
            ST_SETB: begin
                mem_we    = 1'b1;
                mem_addr  = base_q;
                mem_wdata = ~bg_q;
            end
            ST_SWEEP: begin
                mem_en = 1'b1;
                if (order_q == ORD_GALLOP && half_q) begin
                    mem_addr = base_q;
                    rd_tag   = '{valid: 1'b1, exp: ~bg_q};
                end else begin
                    mem_addr = other;
                    rd_tag   = '{valid: 1'b1, exp: bg_q};
                end
            end
            ST_LAST: begin
                mem_en   = 1'b1;
                mem_addr = base_q;
                rd_tag   = '{valid: 1'b1, exp: ~bg_q};
            end
            default: ;
        endcase
    end

    logic end_base;
    always_comb begin
        end_base = 1'b0;
        if (state_q == ST_LAST)
            end_base = 1'b1;
        else if (state_q == ST_SWEEP && idx_q == TOP_OTHER)
            end_base = (order_q == ORD_GALLOP) ? half_q : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            order_q <= ORD_GALLOP;
            bg_q    <= 1'b0;
            base_q  <= '0;
            idx_q   <= '0;
            half_q  <= 1'b0;
        end else if (end_base) begin
            idx_q  <= '0;
            half_q <= 1'b0;
            if (base_q == TOP_ADDR) begin
                base_q <= '0;
                if (bg_q) begin
                    state_q <= ST_DRAIN;
                end else begin
                    bg_q    <= 1'b1;
                    state_q <= ST_FILL;
                end
            end else begin
                base_q  <= base_q + AW'(1);
                state_q <= ST_FILL;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_FILL;
                    order_q <= bc_order_e'(mode);
                    bg_q    <= 1'b0;
                    base_q  <= '0;
                    idx_q   <= '0;
                    half_q  <= 1'b0;
                end
                ST_FILL: begin
                    if (idx_q == TOP_ADDR) begin
                        idx_q   <= '0;
                        state_q <= ST_SETB;
                    end else begin
                        idx_q <= idx_q + AW'(1);
                    end
                end
                ST_SETB: begin
                    idx_q   <= '0;
                    half_q  <= 1'b0;
                    state_q <= ST_SWEEP;
                end
                ST_SWEEP: begin
                    if (order_q == ORD_GALLOP) begin
                        half_q <= ~half_q;
                        if (half_q) idx_q <= idx_q + AW'(1);
                    end else if (idx_q == TOP_OTHER) begin
                        state_q <= ST_LAST;
                    end else begin
                        idx_q <= idx_q + AW'(1);
                    end
                end
                ST_DRAIN: state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: done lasts one cycle and busy is low while it is high
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_not_busy_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R3: in galloping order an other-cell read is followed by a base read
    p_gallop_return_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWEEP && order_q == ORD_GALLOP && !half_q)
        |=> (mem_en && mem_addr == base_q));
    // R4: in walking order the sweep never touches the base
    p_walk_skip_base_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWEEP && order_q == ORD_WALK) |-> (mem_addr != base_q));
    // R10: no memory traffic when idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_en && !mem_we));

endmodule

// File: rtl/bcell_chk.sv
module bcell_chk
    import bcell_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  bc_rdtag_t     rd_tag,
    input  logic [AW-1:0] rd_addr,
    input  logic          mem_rdata,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic          fail_exp
);

    bc_rdtag_t     pend_q;
    logic [AW-1:0] pend_addr_q;
    logic          mismatch;

    assign mismatch = pend_q.valid && (mem_rdata != pend_q.exp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            pend_addr_q <= '0;
        end else begin
            pend_q      <= rd_tag;
            pend_addr_q <= rd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= 1'b0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr_q;
            fail_exp  <= pend_q.exp;
        end
    end

    // R7: the flag is sticky until a start clears it
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> fail);
    // R8: first-failure record is frozen once captured
    p_first_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> ($stable(fail_addr) && $stable(fail_exp)));

endmodule

// File: rtl/bcell_tester.sv
module bcell_tester
    import bcell_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          mode,
    output logic [AW-1:0] mem_addr,
    output logic          mem_en,
    output logic          mem_we,
    output logic          mem_wdata,
    input  logic          mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic          fail_exp
);

    initial assert (bc_size_ok(N));

    bc_rdtag_t rd_tag;
    logic      clear;

    bcell_seq #(.N(N), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode      (mode),
        .mem_addr  (mem_addr),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .rd_tag    (rd_tag),
        .busy      (busy),
        .done      (done),
        .clear     (clear)
    );

    bcell_chk #(.AW(AW)) u_chk (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .rd_tag    (rd_tag),
        .rd_addr   (mem_addr),
        .mem_rdata (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp)
    );

    // R11: accepting start is always followed by a clean fail flag
    p_clear_on_start_r11: assert property (@(posedge clk) disable iff (rst)
        clear |=> !fail);

endmodule

// File: tb/tb_bcell_tester.sv
module tb_bcell_tester;

    localparam int N      = 8;
    localparam int AW     = $clog2(N);
    localparam int CLK_NS = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mode = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_en, mem_we, mem_wdata;
    logic          mem_rdata = 1'b0;
    logic          busy, done, fail, fail_exp;
    logic [AW-1:0] fail_addr;

    int total = 0;
    int bad   = 0;

    always #(CLK_NS / 2) clk = ~clk;

    bcell_tester #(.N(N)) dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp)
    );

    // behavioural memory under test with optional fault
    int   fkind = 0;   // 0 none, 1 stuck-at, 2 bridge aggressor->victim
    int   fa = 0, fb = 0;
    logic bmem [N];
    logic          cap_en = 1'b0, cap_we = 1'b0, cap_wd = 1'b0;
    logic [AW-1:0] cap_addr = '0;

    always @(negedge clk) begin
        cap_en   = mem_en;
        cap_we   = mem_we;
        cap_wd   = mem_wdata;
        cap_addr = mem_addr;
    end

    always @(posedge clk) begin
        if (cap_we) begin
            bmem[cap_addr] <= cap_wd;
            if (fkind == 2 && int'(cap_addr) == fa) bmem[fb] <= cap_wd;
        end
        if (cap_en) begin
            if (fkind == 1 && int'(cap_addr) == fa) mem_rdata <= fb[0];
            else                                   mem_rdata <= bmem[cap_addr];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference operation stream: kind 1 = write, 2 = read
    int q_kind[$];
    int q_addr[$];
    int q_val[$];

    function automatic void push(int k, int a, int v);
        q_kind.push_back(k); q_addr.push_back(a); q_val.push_back(v);
    endfunction

    function automatic void build(bit walk);
        q_kind.delete(); q_addr.delete(); q_val.delete();
        for (int bg = 0; bg < 2; bg++) begin          // R6
            for (int b = 0; b < N; b++) begin          // R5
                for (int a = 0; a < N; a++) push(1, a, bg);   // R2
                push(1, b, 1 - bg);
                for (int c = 0; c < N; c++) begin
                    if (c == b) continue;
                    push(2, c, bg);
                    if (!walk) push(2, b, 1 - bg);     // R3
                end
                if (walk) push(2, b, 1 - bg);          // R4
            end
        end
    endfunction

    task automatic run(input bit walk, input bit poke);
        int  cyc = 0, drain = 0;
        bit  ef = 0;  int efa = 0, efe = 0;
        bit  pend = 0; int pexp = 0, paddr = 0;
        bit  finished = 0;
        build(walk);
        @(negedge clk);
        mode  = walk;
        start = 1'b1;
        while (!finished) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) begin
                start = 1'b0;
                chk(fail == 1'b0, "R11 fail cleared", fail, 0);
            end
            if (poke && cyc == 40) begin start = 1'b1; mode = ~mode; end   // R1 R9
            if (poke && cyc == 41) start = 1'b0;
            // compare model read data (R7)
            chk(fail == ef, "R7 fail flag", fail, ef);
            if (pend && !ef && (mem_rdata !== pexp[0])) begin
                ef = 1; efa = paddr; efe = pexp;
            end
            pend = 0;
            if (q_kind.size() != 0) begin
                chk(busy && !done, "R1 busy during test", {busy, done}, 2);
                if (q_kind[0] == 1) begin
                    chk(mem_we && !mem_en && int'(mem_addr) == q_addr[0] && int'(mem_wdata) == q_val[0],
                        "R2 write op", int'(mem_addr) * 2 + mem_wdata, q_addr[0] * 2 + q_val[0]);
                end else begin
                    chk(mem_en && !mem_we && int'(mem_addr) == q_addr[0],
                        walk ? "R4 read op" : "R3 read op", int'(mem_addr), q_addr[0]);
                    pend = 1; pexp = q_val[0]; paddr = q_addr[0];
                end
                void'(q_kind.pop_front()); void'(q_addr.pop_front()); void'(q_val.pop_front());
            end else begin
                drain++;
                if (drain == 1) begin
                    chk(busy && !done && !mem_en && !mem_we, "R12 drain cycle", {busy, done}, 2);
                end else begin
                    chk(done && !busy, "R12 done after drain", {busy, done}, 1);
                    finished = 1;
                end
            end
            if (cyc > 5000) begin
                chk(0, "watchdog", cyc, 0);
                finished = 1;
            end
        end
        @(negedge clk);
        chk(!done && !busy, "R1 done one cycle", {busy, done}, 0);
        chk(fail == ef, "R8 final fail", fail, ef);
        if (ef) begin
            chk(int'(fail_addr) == efa, "R8 fail_addr", fail_addr, efa);
            chk(int'(fail_exp) == efe, "R8 fail_exp", fail_exp, efe);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !done && !fail && !mem_en && !mem_we, "R10 reset state",
            {busy, done, fail, mem_en, mem_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_en && !mem_we, "R10 idle after reset", {busy, mem_en, mem_we}, 0);

        fkind = 0; run(1'b0, 1'b0);                   // clean galloping
        fkind = 0; run(1'b1, 1'b0);                   // clean walking
        fkind = 1; fa = 3; fb = 0; run(1'b0, 1'b1);   // stuck-at-0, galloping, mid-run pokes
        fkind = 1; fa = 0; fb = 1; run(1'b1, 1'b0);   // stuck-at-1 at address 0, walking
        fkind = 2; fa = 2; fb = 5; run(1'b0, 1'b0);   // bridge 2 -> 5, galloping
        chk(fail_addr == 3'd5 && fail_exp == 1'b0, "R8 bridge victim", fail_addr, 5);
        fkind = 2; fa = 6; fb = 1; run(1'b1, 1'b1);   // bridge 6 -> 1, walking, pokes
        fkind = 0; run(1'b1, 1'b0);                   // R11: clean after failing run
        chk(!fail, "R11 clean run after fail", fail, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule